// File: doc/BRIEF.md
# Linear Frequency Sweep Controller

This block produces a frequency tuning word that ramps in straight-line steps between a programmable start word and a programmable end word. A profile pin steers the ramp. While it is high the word climbs toward the end word by a rising step size at a rising step interval. While it is low the word descends toward the start word by a separate falling step size at a separate falling step interval. A no-dwell option changes the top of the ramp: instead of parking at the end word, the word snaps back to the start word and waits there.

Internally the ramp is an offset accumulator, called the sweep accumulator, that is added to the start word. A 32-bit phase accumulator integrates the registered tuning word on every clock and gives the phase output. Each of the two accumulators has two clear controls. A static hold keeps it at zero for as long as the hold is high. An auto-clear zeroes it for a single cycle on every update strobe or profile-pin change, and it repeats on each such event while the auto-clear bit stays set.

Top module: `lsw_sweep_ctrl`

## Requirements
- R1: In reset both `ftw_word` and `phase_word` read 0. On the first clock after reset is released, `ftw_word` equals `start_word`.
- R2: With `profile` high, `ftw_word` rises by `rise_step` on each step. A step that would pass `end_word` lands exactly on `end_word`. The design assumes `end_word >= start_word`.
- R3: With `profile` low, `ftw_word` falls by `fall_step` on each step. A step that would pass `start_word` lands exactly on `start_word`.
- R4: A change on `profile` reloads the step timer with the interval of the new direction (`rise_interval` when high, `fall_interval` when low). The first step shows on `ftw_word` N+1 clocks after the clock edge that samples the change, and later steps follow every N+1 clocks, where N is that interval.
- R5: With `no_dwell` low, `ftw_word` holds at `end_word` for as long as `profile` stays high.
- R6: With `no_dwell` high, `ftw_word` returns to `start_word` one clock after it reaches `end_word`. It then stays at `start_word` until `profile` changes.
- R7: While `sweep_hold` is high, the sweep accumulator is held at zero, so on the next clock `ftw_word` equals `start_word`. The ramp resumes from there once the hold is released.
- R8: While `phase_hold` is high, `phase_word` is 0 on the next clock.
- R9: With `sweep_autoclr` set, each `update` pulse or `profile` change zeroes the sweep accumulator for one cycle, so `ftw_word` shows `start_word` on the next clock. The sweep is then released.
- R10: With `phase_autoclr` set, each `update` pulse or `profile` change makes `phase_word` 0 on the next clock. Accumulation resumes after that.
- R11: In all other cycles, `phase_word` advances by the previous `ftw_word`, modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| profile | input | 1 | Sweep direction: 1 ramps toward the end word, 0 ramps toward the start word |
| update | input | 1 | Update strobe that triggers the auto-clears |
| no_dwell | input | 1 | Snap back to the start word when the end word is reached |
| sweep_hold | input | 1 | Static hold-at-zero for the sweep accumulator |
| sweep_autoclr | input | 1 | One-shot sweep clear on each update or profile change |
| phase_hold | input | 1 | Static hold-at-zero for the phase accumulator |
| phase_autoclr | input | 1 | One-shot phase clear on each update or profile change |
| start_word | input | 32 | Lower sweep limit |
| end_word | input | 32 | Upper sweep limit |
| rise_step | input | 32 | Increment per rising step |
| fall_step | input | 32 | Decrement per falling step |
| rise_interval | input | 8 | Clocks between rising steps, minus one |
| fall_interval | input | 8 | Clocks between falling steps, minus one |
| ftw_word | output | 32 | Current frequency tuning word (registered) |
| phase_word | output | 32 | Phase accumulator output (registered) |

## Verification
The bench targets these corner cases and the failure each one would expose:
- Saturation at both limits. A wrong limit check would overshoot `end_word`, or wrap below `start_word` when the falling step exceeds the remaining offset.
- Exact step timing after a direction change. An off-by-one timer reload would move the first step a clock early or late.
- No-dwell snap-back. A broken snap-back would either park at the end word or restart the ramp while the profile stays high.
- Clear events landing on the same cycle as a step or a profile edge. These check that holds and auto-clears win over stepping and that they re-arm on every event. A design that got this wrong would leave a stale offset or phase behind the clear.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  typedef enum logic {
    DIR_FALL = 1'b0,
    DIR_RISE = 1'b1
  } sweep_dir_e;
endpackage

// File: rtl/lsw_rate_timer.sv
module lsw_rate_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              restart,
  input  logic [RATE_W-1:0] load_val,
  output logic              tick
);
  logic [RATE_W-1:0] cnt;

  // a step fires only when the count has run out and nothing reloads it
  always_comb tick = !hold && !restart && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (hold || restart || tick) begin
      cnt <= load_val;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/lsw_sweep_acc.sv
module lsw_sweep_acc #(
  parameter int FTW_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             clear,
  input  logic             edge_i,
  input  logic             rising,
  input  logic             no_dwell,
  input  logic             tick,
  input  logic [FTW_W-1:0] start_word,
  input  logic [FTW_W-1:0] end_word,
  input  logic [FTW_W-1:0] rise_step,
  input  logic [FTW_W-1:0] fall_step,
  output logic [FTW_W-1:0] ftw_o
);
  localparam int SUM_W = FTW_W + 1;

  logic [FTW_W-1:0] acc, acc_d, span;
  logic [SUM_W-1:0] rise_sum;
  logic             done, done_d;

  always_comb begin
    span     = end_word - start_word;
    rise_sum = {1'b0, acc} + {1'b0, rise_step};
    acc_d    = acc;
    done_d   = done;
    if (hold || clear) begin
      acc_d  = '0;
      done_d = 1'b0;
    end else if (edge_i) begin
      done_d = 1'b0;
    end else if (rising && no_dwell && (acc >= span) && !done) begin
      acc_d  = '0;
      done_d = 1'b1;
    end else if (tick) begin
      if (rising) begin
        if (!done) begin
          acc_d = (rise_sum >= {1'b0, span}) ? span : rise_sum[FTW_W-1:0];
        end
      end else begin
        acc_d = (acc > fall_step) ? (acc - fall_step) : '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      done  <= 1'b0;
      ftw_o <= '0;
    end else begin
      acc   <= acc_d;
      done  <= done_d;
      ftw_o <= start_word + acc_d;
    end
  end
endmodule

// File: rtl/lsw_phase_acc.sv
module lsw_phase_acc #(
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold,
  input  logic               clear,
  input  logic [FTW_W-1:0]   ftw,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] inc;

  generate
    if (PHASE_W >= FTW_W) begin : g_ext
      assign inc = {{(PHASE_W-FTW_W){1'b0}}, ftw};
    end else begin : g_trunc
      assign inc = ftw[FTW_W-1 -: PHASE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || hold || clear) begin
      phase_o <= '0;
    end else begin
      phase_o <= phase_o + inc;
    end
  end
endmodule

// File: rtl/lsw_sweep_ctrl.sv
module lsw_sweep_ctrl
  import lsw_pkg::*;
#(
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 32,
  parameter int RATE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               profile,
  input  logic               update,
  input  logic               no_dwell,
  input  logic               sweep_hold,
  input  logic               sweep_autoclr,
  input  logic               phase_hold,
  input  logic               phase_autoclr,
  input  logic [FTW_W-1:0]   start_word,
  input  logic [FTW_W-1:0]   end_word,
  input  logic [FTW_W-1:0]   rise_step,
  input  logic [FTW_W-1:0]   fall_step,
  input  logic [RATE_W-1:0]  rise_interval,
  input  logic [RATE_W-1:0]  fall_interval,
  output logic [FTW_W-1:0]   ftw_word,
  output logic [PHASE_W-1:0] phase_word
);
  sweep_dir_e        dir_q;
  logic              prof_edge, clr_evt, tick, restart;
  logic [RATE_W-1:0] iv_sel;

  always_ff @(posedge clk) begin
    if (rst) dir_q <= DIR_FALL;
    else     dir_q <= profile ? DIR_RISE : DIR_FALL;
  end

  always_comb begin
    prof_edge = (dir_q == DIR_RISE) != profile;
    clr_evt   = update || prof_edge;
    restart   = prof_edge || (update && sweep_autoclr);
    iv_sel    = profile ? rise_interval : fall_interval;
  end

  lsw_rate_timer #(.RATE_W(RATE_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .hold     (sweep_hold),
    .restart  (restart),
    .load_val (iv_sel),
    .tick     (tick)
  );

  lsw_sweep_acc #(.FTW_W(FTW_W)) u_sweep (
    .clk        (clk),
    .rst        (rst),
    .hold       (sweep_hold),
    .clear      (clr_evt && sweep_autoclr),
    .edge_i     (prof_edge),
    .rising     (dir_q == DIR_RISE),
    .no_dwell   (no_dwell),
    .tick       (tick),
    .start_word (start_word),
    .end_word   (end_word),
    .rise_step  (rise_step),
    .fall_step  (fall_step),
    .ftw_o      (ftw_word)
  );

  lsw_phase_acc #(.FTW_W(FTW_W), .PHASE_W(PHASE_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .hold    (phase_hold),
    .clear   (clr_evt && phase_autoclr),
    .ftw     (ftw_word),
    .phase_o (phase_word)
  );
endmodule

// File: rtl/lsw_sweep_checker.sv
module lsw_sweep_checker #(
  parameter int FTW_W   = 32,
  parameter int PHASE_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               profile,
  input logic               update,
  input logic               sweep_hold,
  input logic               sweep_autoclr,
  input logic               phase_hold,
  input logic               phase_autoclr,
  input logic [FTW_W-1:0]   start_word,
  input logic [FTW_W-1:0]   end_word,
  input logic [FTW_W-1:0]   ftw_word,
  input logic [PHASE_W-1:0] phase_word
);
  logic [1:0] age;
  logic       prof_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      age       <= '0;
      prof_prev <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 1'b1;
      prof_prev <= profile;
    end
  end

  p_sweep_hold_r7: assert property (@(posedge clk) disable iff (rst)
    sweep_hold |=> ftw_word == $past(start_word));

  p_phase_hold_r8: assert property (@(posedge clk) disable iff (rst)
    phase_hold |=> phase_word == '0);

  p_sweep_autoclr_r9: assert property (@(posedge clk) disable iff (rst)
    (sweep_autoclr && update) |=> ftw_word == $past(start_word));

  p_phase_autoclr_r10: assert property (@(posedge clk) disable iff (rst)
    (phase_autoclr && update) |=> phase_word == '0);

  p_phase_adds_r11: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !phase_hold &&
     !(phase_autoclr && (update || (profile != prof_prev))))
    |=> phase_word == $past(phase_word) + PHASE_W'($past(ftw_word)));

  p_fall_mono_r3: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !profile && !prof_prev && !update && !sweep_hold &&
     $stable(start_word) && $stable(end_word))
    |=> ftw_word <= $past(ftw_word));
endmodule

bind lsw_sweep_ctrl lsw_sweep_checker #(.FTW_W(FTW_W), .PHASE_W(PHASE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .profile       (profile),
  .update        (update),
  .sweep_hold    (sweep_hold),
  .sweep_autoclr (sweep_autoclr),
  .phase_hold    (phase_hold),
  .phase_autoclr (phase_autoclr),
  .start_word    (start_word),
  .end_word      (end_word),
  .ftw_word      (ftw_word),
  .phase_word    (phase_word)
);

// File: tb/lsw_sweep_ctrl_tb.sv
module lsw_sweep_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic profile = 0, update = 0, no_dwell = 0;
  logic sweep_hold = 0, sweep_autoclr = 0, phase_hold = 0, phase_autoclr = 0;
  logic [31:0] start_w = 0, end_w = 0, rise_step = 0, fall_step = 0;
  logic [7:0]  rise_iv = 0, fall_iv = 0;
  logic [31:0] ftw, phase;

  int    n_run = 0, n_fail = 0;
  bit    cmp_en = 0, finished = 0;
  string lbl = "R1";

  always #10 clk = ~clk;

  lsw_sweep_ctrl u_dut (
    .clk(clk), .rst(rst), .profile(profile), .update(update), .no_dwell(no_dwell),
    .sweep_hold(sweep_hold), .sweep_autoclr(sweep_autoclr),
    .phase_hold(phase_hold), .phase_autoclr(phase_autoclr),
    .start_word(start_w), .end_word(end_w), .rise_step(rise_step), .fall_step(fall_step),
    .rise_interval(rise_iv), .fall_interval(fall_iv),
    .ftw_word(ftw), .phase_word(phase)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference behaviour built from the requirements
  logic        m_prof, m_done;
  logic [7:0]  m_cnt;
  logic [31:0] m_acc, m_ftw, m_ph;

  function automatic logic [31:0] sat_up(logic [31:0] a, logic [31:0] s, logic [31:0] sp);
    logic [32:0] t = {1'b0, a} + {1'b0, s};
    return (t >= {1'b0, sp}) ? sp : t[31:0];
  endfunction

  function automatic logic [31:0] sat_dn(logic [31:0] a, logic [31:0] s);
    return (a > s) ? a - s : 32'd0;
  endfunction

  always @(posedge clk) begin : model
    logic e, ev, tk, nd;
    logic [7:0]  iv, nc;
    logic [31:0] sp, na;
    if (rst) begin
      m_prof <= 0; m_done <= 0; m_cnt <= 0; m_acc <= 0; m_ftw <= 0; m_ph <= 0;
    end else begin
      e  = profile != m_prof;
      ev = update || e;
      iv = profile ? rise_iv : fall_iv;
      tk = 0;
      if (sweep_hold || e || (update && sweep_autoclr)) nc = iv;
      else if (m_cnt == 0) begin nc = iv; tk = 1; end
      else nc = m_cnt - 1;
      sp = end_w - start_w; na = m_acc; nd = m_done;
      if (sweep_hold || (ev && sweep_autoclr)) begin na = 0; nd = 0; end
      else if (e) nd = 0;
      else if (m_prof && no_dwell && m_acc >= sp && !m_done) begin na = 0; nd = 1; end
      else if (tk) begin
        if (m_prof) begin if (!m_done) na = sat_up(m_acc, rise_step, sp); end
        else na = sat_dn(m_acc, fall_step);
      end
      m_prof <= profile; m_cnt <= nc; m_acc <= na; m_done <= nd;
      m_ftw  <= start_w + na;
      m_ph   <= (phase_hold || (ev && phase_autoclr)) ? 32'd0 : m_ph + m_ftw;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !rst) begin
      chk({lbl, " ftw (R2 R3 R4 R7 R9)"}, ftw, m_ftw);
      chk({lbl, " phase (R8 R10 R11)"}, phase, m_ph);
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    start_w = 1000; end_w = 1100; rise_step = 30; fall_step = 40;
    rise_iv = 2; fall_iv = 1;
    wait_n(3);
    chk("R1 reset ftw", ftw, 0);
    chk("R1 reset phase", phase, 0);
    rst = 0;
    wait_n(1);
    chk("R1 first ftw after reset", ftw, 1000);
    cmp_en = 1;
    wait_n(5);

    // R4 timing: rising interval 2 -> first step three clocks after the sampling edge
    lbl = "R4"; profile = 1;
    wait_n(3);
    chk("R4 before first step", ftw, 1000);
    wait_n(1);
    chk("R4 first step", ftw, 1030);
    wait_n(3);
    chk("R4 second step", ftw, 1060);
    lbl = "R5";
    wait_n(20);
    chk("R2 R5 saturate and dwell at end", ftw, 1100);

    lbl = "R3"; profile = 0;
    wait_n(20);
    chk("R3 saturate at start", ftw, 1000);

    // R6: no-dwell snap-back
    lbl = "R6"; no_dwell = 1; profile = 1;
    wait_n(30);
    chk("R6 back at start after end", ftw, 1000);
    profile = 0; wait_n(5); no_dwell = 0;

    // R7/R8 holds
    lbl = "R7"; profile = 1; wait_n(4); sweep_hold = 1; phase_hold = 1;
    wait_n(2);
    chk("R7 sweep hold", ftw, 1000);
    chk("R8 phase hold", phase, 0);
    sweep_hold = 0; phase_hold = 0;
    wait_n(10);

    // R9/R10 auto-clear on update, re-armed
    lbl = "R9"; sweep_autoclr = 1; phase_autoclr = 1;
    for (int k = 0; k < 3; k++) begin
      wait_n(3); update = 1; wait_n(1); update = 0;
      chk("R9 sweep autoclear", ftw, 1000);
      chk("R10 phase autoclear", phase, 0);
    end
    sweep_autoclr = 0; phase_autoclr = 0;

    // random mix, compared every cycle against the model
    lbl = "R11 random";
    for (int blk = 0; blk < 20; blk++) begin
      start_w   = $urandom % 1000000;
      end_w     = start_w + ($urandom % 5000);
      rise_step = 1 + ($urandom % 900);
      fall_step = 1 + ($urandom % 900);
      rise_iv   = $urandom % 8;
      fall_iv   = $urandom % 8;
      no_dwell  = $urandom % 2;
      sweep_autoclr = ($urandom % 4) == 0;
      phase_autoclr = ($urandom % 4) == 0;
      for (int c = 0; c < 200; c++) begin
        if (($urandom % 40) == 0) profile = ~profile;
        update     = ($urandom % 60) == 0;
        sweep_hold = ($urandom % 100) < 2;
        phase_hold = ($urandom % 100) < 2;
        wait_n(1);
      end
    end
    update = 0; sweep_hold = 0; phase_hold = 0;
    wait_n(2);
    finished = 1;
    summary();
  end
endmodule